// File: doc/BRIEF.md
# Leading-One Encoder

This block takes a wide data word and, within a single clock cycle, finds its most significant set bit. It reports that bit in three forms: a one-hot mask, a 0-based binary index counted from the LSB, and a flag that is raised when the word holds no set bit at all. It also drives a thermometer mask that is high from the found bit up to the MSB. Typical users are normalisers, arbiters and free-list scanners that need the top request or the highest live entry of a vector that is too wide for a plain priority tree to meet timing.

The search is arithmetic rather than a mux tree. The word is mirrored so that its MSB becomes bit 0, and the lowest set bit of the mirrored word is then isolated by one carry-propagating operation. A parameter selects between two equivalent forms: add one to the inverted word, or subtract one from the word itself. Because the carry runs through the whole width, synthesis can place it on a dedicated carry chain. The one-hot mask then goes through an OR-plane encoder to give the index. A second parameter adds one register stage after all outputs, for callers that want a clean timing boundary.

Top module: `leadOneEncoder`

## Requirements
- R1: `oneHot` has exactly one bit set, at the position of the most significant 1 of the input word. It is all zeros when the input is zero.
- R2: `index` is the position of that bit, counted from 0 at the LSB. `index` is 0 when the input is zero.
- R3: `zero` is 1 exactly when every input bit is 0, and 0 otherwise.
- R4: `thermo` bit i is 1 exactly when i is greater than or equal to the found position. `thermo` is all ones when the input is zero.
- R5: The subtract form (FORM = FORM_DEC) gives the same value as the add form (FORM = FORM_ADD) on every output, for every input word.
- R6: With REG_OUT = 0 the outputs follow the input in the same cycle. With REG_OUT = 1 they show the input sampled at the previous rising clock edge, so a change of the input is not visible before that edge.
- R7: With REG_OUT = 1, while `rstN` is low, the outputs hold the all-zero-input result: `oneHot` = 0, `thermo` = all ones, `index` = 0, `zero` = 1.
- R8: At the default width of 66, every bit position from 0 to 65 is found and encoded correctly, whatever pattern the bits below it hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset of the output register |
| dataIn | input | WIDTH | Word to be scanned |
| oneHot | output | WIDTH | Mask of the most significant set bit |
| thermo | output | WIDTH | Ones from the found bit up to the MSB |
| index | output | IDXW | Binary position of the found bit |
| zero | output | 1 | Input word has no set bit |

## Verification
The bench sweeps every 8-bit word through a registered add-form instance and a combinational subtract-form instance, and compares both against an arithmetic reference. This exposes a mirror that is wired the wrong way: such a design would report the lowest set bit rather than the highest. It would also catch an XOR/XNOR swap, which corrupts the thermometer, and an encoder that mixes up index bits. The all-zero word is the sharpest corner. There, a wrong carry polarity would set `zero` on full words instead of empty ones, and the thermometer must come out all ones. Words whose MSB or LSB alone is set check the ends of the carry chain. Checks placed before the clock edge catch a register stage that leaks the new input early. A sweep of every position across the full 66-bit width, with noise below the top bit, catches a carry that stops short of the upper word.

// File: rtl/lod_pkg.sv
package lod_pkg;

  // Carry formulation used to isolate the top set bit.
  typedef enum logic {
    FORM_ADD = 1'b0,  // mirror, invert, add one
    FORM_DEC = 1'b1   // mirror, subtract one
  } lodForm_e;

  // Bits needed to hold a position in a word of w bits.
  function automatic int idxBits(input int w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction

endpackage

// File: rtl/lodScanPath.sv
module lodScanPath #(
  parameter int              WIDTH = 66,
  parameter lod_pkg::lodForm_e FORM = lod_pkg::FORM_ADD
) (
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] oneHot,
  output logic [WIDTH-1:0] thermo,
  output logic             zero
);

  logic [WIDTH-1:0] revIn;
  logic [WIDTH-1:0] maskRev;
  logic [WIDTH-1:0] thermRev;

  // Mirror the word so its MSB sits where the carry enters.
  for (genvar i = 0; i < WIDTH; i++) begin : gMirrorIn
    assign revIn[i] = dataIn[WIDTH-1-i];
  end

  if (FORM == lod_pkg::FORM_ADD) begin : gAdd
    logic [WIDTH:0] sumExt;
    logic [WIDTH-1:0] sumLo;
    assign sumExt   = {1'b0, ~revIn} + (WIDTH+1)'(1);
    assign sumLo    = sumExt[WIDTH-1:0];
    assign maskRev  = revIn & sumLo;
    assign thermRev = ~(revIn ^ sumLo);
    assign zero     = sumExt[WIDTH];   // carry leaves only when the word is empty
  end else begin : gDec
    logic [WIDTH:0] diffExt;
    logic [WIDTH-1:0] diffLo;
    assign diffExt  = {1'b0, revIn} - (WIDTH+1)'(1);
    assign diffLo   = diffExt[WIDTH-1:0];
    assign maskRev  = revIn & ~diffLo;
    assign thermRev = revIn ^ diffLo;
    assign zero     = diffExt[WIDTH];  // borrow leaves only when the word is empty
  end

  // Mirror the results back into the caller's bit order.
  for (genvar i = 0; i < WIDTH; i++) begin : gMirrorOut
    assign oneHot[i] = maskRev[WIDTH-1-i];
    assign thermo[i] = thermRev[WIDTH-1-i];
  end

endmodule

// File: rtl/lodIndexEnc.sv
module lodIndexEnc #(
  parameter int WIDTH = 66,
  parameter int IDXW  = lod_pkg::idxBits(WIDTH)
) (
  input  logic [WIDTH-1:0] oneHot,
  output logic [IDXW-1:0]  index
);

  // Each index bit is the OR of the mask bits whose position has it set.
  for (genvar j = 0; j < IDXW; j++) begin : gBit
    always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
        if (((i >> j) & 1) == 1) acc = acc | oneHot[i];
      end
      index[j] = acc;
    end
  end

endmodule

// File: rtl/lodOutStage.sv
module lodOutStage #(
  parameter int WIDTH   = 66,
  parameter int IDXW    = lod_pkg::idxBits(WIDTH),
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] oneHotD,
  input  logic [WIDTH-1:0] thermoD,
  input  logic [IDXW-1:0]  indexD,
  input  logic             zeroD,
  output logic [WIDTH-1:0] oneHotQ,
  output logic [WIDTH-1:0] thermoQ,
  output logic [IDXW-1:0]  indexQ,
  output logic             zeroQ
);

  logic [WIDTH-1:0] oneHotR;
  logic [WIDTH-1:0] thermoR;
  logic [IDXW-1:0]  indexR;
  logic             zeroR;

  // Reset value is the result for an empty word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oneHotR <= '0;
      thermoR <= '1;
      indexR  <= '0;
      zeroR   <= 1'b1;
    end else begin
      oneHotR <= oneHotD;
      thermoR <= thermoD;
      indexR  <= indexD;
      zeroR   <= zeroD;
    end
  end

  if (REG_OUT) begin : gReg
    assign oneHotQ = oneHotR;
    assign thermoQ = thermoR;
    assign indexQ  = indexR;
    assign zeroQ   = zeroR;
  end else begin : gComb
    // The register is left unloaded here and is trimmed away.
    logic unusedRegs;
    assign unusedRegs = ^{oneHotR, thermoR, indexR, zeroR};
    assign oneHotQ = oneHotD;
    assign thermoQ = thermoD;
    assign indexQ  = indexD;
    assign zeroQ   = zeroD;
  end

endmodule

// File: rtl/leadOneEncoder.sv
module leadOneEncoder #(
  parameter int                WIDTH   = 66,
  parameter lod_pkg::lodForm_e FORM    = lod_pkg::FORM_ADD,
  parameter bit                REG_OUT = 1'b0,
  localparam int               IDXW    = lod_pkg::idxBits(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] oneHot,
  output logic [WIDTH-1:0] thermo,
  output logic [IDXW-1:0]  index,
  output logic             zero
);

  logic [WIDTH-1:0] scanHot;
  logic [WIDTH-1:0] scanTherm;
  logic             scanZero;
  logic [IDXW-1:0]  scanIdx;

  lodScanPath #(.WIDTH(WIDTH), .FORM(FORM)) uScan (
    .dataIn (dataIn),
    .oneHot (scanHot),
    .thermo (scanTherm),
    .zero   (scanZero)
  );

  lodIndexEnc #(.WIDTH(WIDTH), .IDXW(IDXW)) uEnc (
    .oneHot (scanHot),
    .index  (scanIdx)
  );

  lodOutStage #(.WIDTH(WIDTH), .IDXW(IDXW), .REG_OUT(REG_OUT)) uOut (
    .clk     (clk),
    .rstN    (rstN),
    .oneHotD (scanHot),
    .thermoD (scanTherm),
    .indexD  (scanIdx),
    .zeroD   (scanZero),
    .oneHotQ (oneHot),
    .thermoQ (thermo),
    .indexQ  (index),
    .zeroQ   (zero)
  );

endmodule

// File: rtl/leadOneEncoderChk.sv
module leadOneEncoderChk #(
  parameter int WIDTH   = 66,
  parameter int IDXW    = 7,
  parameter bit REG_OUT = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] oneHot,
  input logic [WIDTH-1:0] thermo,
  input logic [IDXW-1:0]  index,
  input logic             zero
);

  logic [WIDTH-1:0] dataPrev;
  logic             primed;
  logic [WIDTH-1:0] refIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataPrev <= '0;
      primed   <= 1'b0;
    end else begin
      dataPrev <= dataIn;
      primed   <= 1'b1;
    end
  end

  assign refIn = REG_OUT ? dataPrev : dataIn;

  AST_ONEHOT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !zero |-> ($countones(oneHot) == 1));                          // R1
  AST_LEAD_OF_INPUT: assert property (@(posedge clk) disable iff (!rstN || !primed)
    (refIn & thermo) == oneHot);                                   // R1
  AST_INDEX_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    !zero |-> (oneHot == (WIDTH'(1) << index)));                   // R2
  AST_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    zero |-> (index == '0));                                       // R2
  AST_ZERO_NOHOT: assert property (@(posedge clk) disable iff (!rstN)
    zero |-> (oneHot == '0));                                      // R3
  AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rstN || !primed)
    zero == (refIn == '0));                                        // R3
  AST_THERM_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !zero |-> ((thermo ^ (thermo << 1)) == oneHot));               // R4
  AST_THERM_FULL: assert property (@(posedge clk) disable iff (!rstN)
    zero |-> (&thermo));                                           // R4

endmodule

bind leadOneEncoder leadOneEncoderChk #(
  .WIDTH(WIDTH), .IDXW(IDXW), .REG_OUT(REG_OUT)
) uChk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .oneHot(oneHot),
  .thermo(thermo), .index(index), .zero(zero)
);

// File: tb/tb_leadOneEncoder.sv
`timescale 1ns/1ps
module tb_leadOneEncoder;

  localparam int SW  = 8;
  localparam int SIW = $clog2(SW);
  localparam int WW  = 66;
  localparam int WIW = $clog2(WW);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SW-1:0] din = '0;
  logic [WW-1:0] wideIn = '0;

  logic [SW-1:0]  hotA, thA, hotB, thB;
  logic [SIW-1:0] idxA, idxB;
  logic           zA, zB;
  logic [WW-1:0]  hotW, thW;
  logic [WIW-1:0] idxW;
  logic           zW;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  // Registered add form
  leadOneEncoder #(.WIDTH(SW), .FORM(lod_pkg::FORM_ADD), .REG_OUT(1'b1)) dut (
    .clk(clk), .rstN(rstN), .dataIn(din),
    .oneHot(hotA), .thermo(thA), .index(idxA), .zero(zA));

  // Combinational subtract form
  leadOneEncoder #(.WIDTH(SW), .FORM(lod_pkg::FORM_DEC), .REG_OUT(1'b0)) dutDec (
    .clk(clk), .rstN(rstN), .dataIn(din),
    .oneHot(hotB), .thermo(thB), .index(idxB), .zero(zB));

  // Default configuration
  leadOneEncoder dutWide (
    .clk(clk), .rstN(rstN), .dataIn(wideIn),
    .oneHot(hotW), .thermo(thW), .index(idxW), .zero(zW));

  function automatic int leadPos(logic [65:0] v, int w);
    for (int i = w - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [65:0] expHot(logic [65:0] v, int w);
    int p = leadPos(v, w);
    return (p < 0) ? 66'(0) : (66'(1) << p);
  endfunction

  function automatic logic [65:0] expTherm(logic [65:0] v, int w);
    int p = leadPos(v, w);
    logic [65:0] wm = (66'(1) << w) - 66'(1);
    if (w >= 66) wm = '1;
    return (p < 0) ? wm : (({66{1'b1}} << p) & wm);
  endfunction

  function automatic logic [65:0] expIdx(logic [65:0] v, int w);
    int p = leadPos(v, w);
    return (p < 0) ? 66'(0) : 66'(p);
  endfunction

  task automatic chk(string tag, logic [65:0] act, logic [65:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkAll(string who, logic [65:0] v, int w,
                        logic [65:0] h, logic [65:0] t, logic [65:0] ix, logic z);
    chk({"R1 oneHot ", who}, h, expHot(v, w));
    chk({"R2 index ", who}, ix, expIdx(v, w));
    chk({"R3 zero ", who}, 66'(z), 66'(v == 0));
    chk({"R4 thermo ", who}, t, expTherm(v, w));
  endtask

  initial begin
    logic [65:0] prev;
    // R7: reset state of the registered instance, input deliberately non-zero
    din = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset oneHot", 66'(hotA), 66'(0));
    chk("R7 reset thermo", 66'(thA), 66'(8'hFF));
    chk("R7 reset index", 66'(idxA), 66'(0));
    chk("R7 reset zero", 66'(zA), 66'(1));
    din = '0;
    rstN = 1'b1;
    @(negedge clk);
    prev = '0;

    // Exhaustive 8-bit sweep (R1..R6)
    for (int v = 0; v < 256; v++) begin
      din = SW'(v);
      #1;
      // R6: registered copy still shows the previous word before the edge
      chk("R6 held before edge", 66'(hotA), expHot(prev, SW));
      chk("R6 held index", 66'(idxA), expIdx(prev, SW));
      // R6 same cycle for combinational, R5 subtract form
      chkAll("R5 dec form", 66'(din), SW, 66'(hotB), 66'(thB), 66'(idxB), zB);
      @(negedge clk);
      chkAll("R6 reg form", 66'(din), SW, 66'(hotA), 66'(thA), 66'(idxA), zA);
      chk("R5 forms agree oneHot", 66'(hotB), 66'(hotA));
      chk("R5 forms agree thermo", 66'(thB), 66'(thA));
      prev = 66'(din);
    end

    // R8: every position of the full default width, with noise below
    wideIn = '0;
    #1;
    chkAll("R8 wide empty", wideIn, WW, hotW, thW, 66'(idxW), zW);
    for (int k = 0; k < WW; k++) begin
      logic [65:0] noise;
      noise = {$urandom, $urandom, $urandom};
      wideIn = (66'(1) << k) | (noise & ((66'(1) << k) - 66'(1)));
      #1;
      chkAll("R8 wide position", wideIn, WW, hotW, thW, 66'(idxW), zW);
    end
    wideIn = '1;
    #1;
    chkAll("R8 wide full", wideIn, WW, hotW, thW, 66'(idxW), zW);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule